// File: doc/BRIEF.md
# Byte-Wide NOR Flash Write-Command Engine

This block is a synthesizable behavioural model of the command logic inside a byte-wide parallel NOR flash. A host drives active-low chip select, output enable and write enable strobes with an address and a data byte, and everything is sampled on one system clock. Writes are taken only as exact unlock-prefixed sequences: one byte program, a 4 KB sector erase, or a whole-array erase. An accepted sequence starts a timed internal busy phase. At the end of that phase a small on-chip byte store is updated.

While the busy phase runs, a read returns synthesized status and not stored data. Bit 7 carries the inverse of the byte being programmed, or 0 during an erase. Bit 6 flips on each new read. Bits 5..0 read 0. The host polls these bits to find the end of the operation. The store keeps a few bytes per sector. Storage is selected by the sector field `addr[SECT_SHIFT +: AW-SECT_SHIFT]` and the low word field `addr[WORD_BITS-1:0]`. Other address bits alias. Operation lengths are clock-cycle parameters.

Top module: `nor_cmd_engine`

## Requirements
- R1: A bus write cycle is the overlap of `ce_n` low, `we_n` low and `oe_n` high. The address is taken in the first clock of the overlap. The data is the value present in the last clock of the overlap. The cycle is acted on in the clock after the overlap ends.
- R2: `data_oe` is 1 exactly while `ce_n` and `oe_n` are both low. Otherwise `data_out` is 0.
- R3: A write of AAh to 5555h, then 55h to 2AAAh, then A0h to 5555h, followed by a fourth write (address A, data D), programs byte A. When the operation completes, byte A becomes its old value AND D.
- R4: The unlock pair, 80h to 5555h, the unlock pair again, and a sixth write of 30h to any address in sector S set every byte of sector S to FFh. Other sectors keep their values.
- R5: The same five-write prefix followed by 10h written to 5555h sets every byte of the store to FFh.
- R6: A write that does not match the next expected step returns the decoder to idle and leaves the store unchanged. No busy phase starts.
- R7: Every write made during a busy phase is ignored and does not start a sequence.
- R8: During a busy phase, read bit 7 is the complement of bit 7 of the program data, or 0 for either erase. Bits 5..0 read 0.
- R9: During a busy phase, each new read returns bit 6 inverted from the previous read. Once idle, reads return stored data.
- R10: A program busy phase lasts PROG_CYCLES clocks after launch. The sector erase and chip erase phases last SECT_CYCLES and CHIP_CYCLES clocks. After that, the new data can be read.
- R11: After reset, every stored byte is FFh, the decoder is idle and no busy phase is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write strobe |
| addr | input | AW | Byte address |
| data_in | input | 8 | Write data from the host |
| data_out | output | 8 | Read data or busy status |
| data_oe | output | 1 | High while the block drives the data bus |

## Verification
The assertions assume that the strobes and the address are synchronous to `clk`. They also assume that a host never overlaps a write strobe with an active output enable, and that the target address stays fixed for the whole read being checked. The bench enforces this by changing every input at the falling clock edge. Each strobe is held for at least two clocks. Every read and write is closed before the next one opens. The bench changes address and data inside a write only in the one test that checks which values are captured.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE, SQ_U1, SQ_U2, SQ_PROG, SQ_E3, SQ_E4, SQ_E5
   } seq_t;

   typedef enum logic [1:0] {
      OP_NONE, OP_PROG, OP_SECT, OP_CHIP
   } op_t;

   localparam logic [7:0] KEY_A     = 8'hAA;
   localparam logic [7:0] KEY_B     = 8'h55;
   localparam logic [7:0] CMD_PROG  = 8'hA0;
   localparam logic [7:0] CMD_ERASE = 8'h80;
   localparam logic [7:0] CMD_SECT  = 8'h30;
   localparam logic [7:0] CMD_CHIP  = 8'h10;
   localparam logic [15:0] ADDR_KEY_A = 16'h5555;
   localparam logic [15:0] ADDR_KEY_B = 16'h2AAA;
endpackage

// File: rtl/nor_bus_strobe.sv
module nor_bus_strobe #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    din,
   output logic          wr_done,
   output logic          rd_act,
   output logic          rd_start,
   output logic [AW-1:0] wa,
   output logic [7:0]    wd
);
   logic wr_act, wr_q, rd_q;

   assign wr_act   = !ce_n && !we_n && oe_n;
   assign rd_act   = !ce_n && !oe_n;
   assign wr_done  = wr_q && !wr_act;
   assign rd_start = rd_act && !rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= 1'b0;
         rd_q <= 1'b0;
         wa   <= '0;
         wd   <= '0;
      end else begin
         wr_q <= wr_act;
         rd_q <= rd_act;
         if (wr_act && !wr_q) wa <= addr;
         if (wr_act)          wd <= din;
      end
   end

   // R1
   wr_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wr_done);
endmodule

// File: rtl/nor_seq_decoder.sv
module nor_seq_decoder
   import nor_cmd_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_done,
   input  logic          busy,
   input  logic [AW-1:0] wa,
   input  logic [7:0]    wd,
   output logic          launch,
   output op_t           launch_op
);
   seq_t state, nxt;
   logic at_a, at_b;

   assign at_a = (wa == AW'(ADDR_KEY_A));
   assign at_b = (wa == AW'(ADDR_KEY_B));

   always_comb begin
      nxt       = state;
      launch    = 1'b0;
      launch_op = OP_NONE;
      if (wr_done && !busy) begin
         nxt = SQ_IDLE;
         case (state)
            SQ_IDLE: if (at_a && wd == KEY_A) nxt = SQ_U1;
            SQ_U1:   if (at_b && wd == KEY_B) nxt = SQ_U2;
            SQ_U2: begin
               if (at_a && wd == CMD_PROG)       nxt = SQ_PROG;
               else if (at_a && wd == CMD_ERASE) nxt = SQ_E3;
            end
            SQ_PROG: begin
               launch    = 1'b1;
               launch_op = OP_PROG;
            end
            SQ_E3: if (at_a && wd == KEY_A) nxt = SQ_E4;
            SQ_E4: if (at_b && wd == KEY_B) nxt = SQ_E5;
            SQ_E5: begin
               if (wd == CMD_SECT) begin
                  launch    = 1'b1;
                  launch_op = OP_SECT;
               end else if (at_a && wd == CMD_CHIP) begin
                  launch    = 1'b1;
                  launch_op = OP_CHIP;
               end
            end
            default: nxt = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SQ_IDLE;
      else        state <= nxt;
   end

   // R7
   no_launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !launch);
endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer
   import nor_cmd_pkg::*;
#(
   parameter int PROG_CYCLES = 40,
   parameter int SECT_CYCLES = 80,
   parameter int CHIP_CYCLES = 120
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  op_t  launch_op,
   output logic busy,
   output op_t  cur_op,
   output logic commit
);
   localparam int MAXC = (PROG_CYCLES > SECT_CYCLES) ?
      ((PROG_CYCLES > CHIP_CYCLES) ? PROG_CYCLES : CHIP_CYCLES) :
      ((SECT_CYCLES > CHIP_CYCLES) ? SECT_CYCLES : CHIP_CYCLES);
   localparam int CW = $clog2(MAXC + 1);

   logic [CW-1:0] cnt, load_val;

   always_comb begin
      case (launch_op)
         OP_PROG: load_val = CW'(PROG_CYCLES - 1);
         OP_SECT: load_val = CW'(SECT_CYCLES - 1);
         default: load_val = CW'(CHIP_CYCLES - 1);
      endcase
   end

   assign commit = busy && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         cur_op <= OP_NONE;
      end else if (launch) begin
         busy   <= 1'b1;
         cnt    <= load_val;
         cur_op <= launch_op;
      end else if (busy) begin
         if (cnt == '0) begin
            busy   <= 1'b0;
            cur_op <= OP_NONE;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   // R10
   busy_from_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(launch));
   // R10
   busy_ends_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(commit));
endmodule

// File: rtl/nor_byte_array.sv
module nor_byte_array
   import nor_cmd_pkg::*;
#(
   parameter int AW         = 16,
   parameter int SECT_SHIFT = 12,
   parameter int WORD_BITS  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic [AW-1:0] tgt_addr,
   input  logic [7:0]    tgt_data,
   input  logic          commit,
   input  op_t           op,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_byte
);
   localparam int SB = AW - SECT_SHIFT;
   localparam int IB = SB + WORD_BITS;
   localparam int NB = 1 << IB;

   logic [NB-1:0][7:0] mem;
   logic [IB-1:0]      pidx, ridx;
   logic [7:0]         pdat;

   assign ridx    = {rd_addr[SECT_SHIFT +: SB], rd_addr[WORD_BITS-1:0]};
   assign rd_byte = mem[ridx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pidx <= '0;
         pdat <= '0;
      end else if (launch) begin
         pidx <= {tgt_addr[SECT_SHIFT +: SB], tgt_addr[WORD_BITS-1:0]};
         pdat <= tgt_data;
      end
   end

   for (genvar i = 0; i < NB; i++) begin : g_byte
      localparam logic [IB-1:0] IDX = IB'(i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem[i] <= 8'hFF;
         end else if (commit) begin
            case (op)
               OP_PROG: if (pidx == IDX) mem[i] <= mem[i] & pdat;
               OP_SECT: if (pidx[IB-1:WORD_BITS] == IDX[IB-1:WORD_BITS]) mem[i] <= 8'hFF;
               OP_CHIP: mem[i] <= 8'hFF;
               default: ;
            endcase
         end
      end
   end

   // R3
   prog_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(commit && op == OP_PROG) |-> ((mem[$past(pidx)] & ~$past(mem[pidx])) == 8'h00));
   // R5
   chip_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(commit && op == OP_CHIP) |-> (&mem));
endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
   import nor_cmd_pkg::*;
#(
   parameter int AW          = 16,
   parameter int SECT_SHIFT  = 12,
   parameter int WORD_BITS   = 2,
   parameter int PROG_CYCLES = 40,
   parameter int SECT_CYCLES = 80,
   parameter int CHIP_CYCLES = 120
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    data_in,
   output logic [7:0]    data_out,
   output logic          data_oe
);
   if (AW < 16) begin : g_bad_aw
      $error("AW must reach the unlock addresses");
   end
   if (SECT_SHIFT >= AW || SECT_SHIFT <= WORD_BITS) begin : g_bad_sect
      $error("SECT_SHIFT must lie between WORD_BITS and AW");
   end
   if (AW - SECT_SHIFT + WORD_BITS > 12) begin : g_bad_size
      $error("byte store too large");
   end
   if (PROG_CYCLES < 1 || SECT_CYCLES < 1 || CHIP_CYCLES < 1) begin : g_bad_time
      $error("operation lengths must be positive");
   end

   logic          wr_done, rd_act, rd_start, launch, busy, commit, tog, prog_b7;
   logic [AW-1:0] wa;
   logic [7:0]    wd, rd_byte, status;
   op_t           launch_op, cur_op;

   nor_bus_strobe #(.AW(AW)) u_bus (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(data_in), .wr_done(wr_done), .rd_act(rd_act),
      .rd_start(rd_start), .wa(wa), .wd(wd));

   nor_seq_decoder #(.AW(AW)) u_dec (
      .clk(clk), .rst_n(rst_n), .wr_done(wr_done), .busy(busy),
      .wa(wa), .wd(wd), .launch(launch), .launch_op(launch_op));

   nor_busy_timer #(.PROG_CYCLES(PROG_CYCLES), .SECT_CYCLES(SECT_CYCLES),
      .CHIP_CYCLES(CHIP_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .launch(launch), .launch_op(launch_op),
      .busy(busy), .cur_op(cur_op), .commit(commit));

   nor_byte_array #(.AW(AW), .SECT_SHIFT(SECT_SHIFT), .WORD_BITS(WORD_BITS)) u_arr (
      .clk(clk), .rst_n(rst_n), .launch(launch), .tgt_addr(wa), .tgt_data(wd),
      .commit(commit), .op(cur_op), .rd_addr(addr), .rd_byte(rd_byte));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog     <= 1'b0;
         prog_b7 <= 1'b0;
      end else if (launch) begin
         tog     <= 1'b0;
         prog_b7 <= wd[7];
      end else if (busy && rd_start) begin
         tog <= ~tog;
      end
   end

   assign status   = {(cur_op == OP_PROG) ? ~prog_b7 : 1'b0, tog, 6'b0};
   assign data_oe  = rd_act;
   assign data_out = rd_act ? (busy ? status : rd_byte) : 8'h00;

   // R8
   erase_dq7_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_oe && busy && cur_op != OP_PROG) |-> !data_out[7]);
   // R9
   toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy && rd_start && !launch) && busy) |-> (tog != $past(tog)));
   // R2
   bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !data_oe |-> (data_out == 8'h00));
endmodule

// File: tb/nor_cmd_engine_tb.sv
module nor_cmd_engine_tb;
   localparam int P = 40, S = 80, C = 120;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [15:0] addr = '0;
   logic [7:0]  data_in = '0;
   logic [7:0]  data_out;
   logic        data_oe;

   always #10 clk = ~clk;

   nor_cmd_engine #(.PROG_CYCLES(P), .SECT_CYCLES(S), .CHIP_CYCLES(C)) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe));

   typedef struct {
      logic [7:0] exp;
      logic [7:0] mask;
      string      tag;
   } item_t;

   item_t q[$];
   event  do_sample;
   int    checks = 0, errors = 0;
   bit    done = 0;
   logic [7:0] model [64];

   function automatic int idx(input logic [15:0] a);
      return int'({a[15:12], a[1:0]});
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   initial begin : monitor
      forever begin
         @(do_sample);
         if (q.size() != 0) begin
            item_t it;
            it = q.pop_front();
            chk(data_oe === 1'b1, {it.tag, " oe"}, {7'b0, data_oe}, 8'h01);
            chk((data_out & it.mask) === (it.exp & it.mask), it.tag,
                data_out & it.mask, it.exp & it.mask);
         end
      end
   end

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; data_in = d; ce_n = 0; we_n = 0;
      repeat (2) @(negedge clk);
      we_n = 1;
      @(negedge clk);
      ce_n = 1;
      @(negedge clk);
   endtask

   task automatic wr_skew(input logic [15:0] a, input logic [15:0] a_late,
                          input logic [7:0] d_early, input logic [7:0] d);
      @(negedge clk);
      addr = a; data_in = d_early; ce_n = 0; we_n = 0;
      @(negedge clk);
      addr = a_late; data_in = d;
      @(negedge clk);
      we_n = 1;
      @(negedge clk);
      ce_n = 1;
      @(negedge clk);
   endtask

   task automatic rd_raw(input logic [15:0] a, output logic [7:0] v);
      @(negedge clk);
      addr = a; ce_n = 0; oe_n = 0;
      repeat (2) @(negedge clk);
      v = data_out;
      oe_n = 1; ce_n = 1;
      @(negedge clk);
   endtask

   task automatic rd_exp(input logic [15:0] a, input logic [7:0] exp,
                         input logic [7:0] mask, input string tag);
      item_t it;
      @(negedge clk);
      addr = a; ce_n = 0; oe_n = 0;
      repeat (2) @(negedge clk);
      it.exp = exp; it.mask = mask; it.tag = tag;
      q.push_back(it);
      ->do_sample;
      @(negedge clk);
      oe_n = 1; ce_n = 1;
      @(negedge clk);
   endtask

   task automatic prefix();
      wr(16'h5555, 8'hAA);
      wr(16'h2AAA, 8'h55);
   endtask

   task automatic erase_prefix();
      prefix();
      wr(16'h5555, 8'h80);
      prefix();
   endtask

   task automatic program_byte(input logic [15:0] a, input logic [7:0] d);
      prefix();
      wr(16'h5555, 8'hA0);
      wr(a, d);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v1, v2, v3;
      for (int i = 0; i < 64; i++) model[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R11 / R2: store erased, bus quiet
      chk(data_oe === 1'b0, "R2 idle oe", {7'b0, data_oe}, 8'h00);
      chk(data_out === 8'h00, "R2 idle data", data_out, 8'h00);
      rd_exp(16'h0000, 8'hFF, 8'hFF, "R11 reset byte0");
      rd_exp(16'h7003, 8'hFF, 8'hFF, "R11 reset byte");
      // R2: ce high, oe low does not drive
      @(negedge clk); oe_n = 0;
      @(negedge clk);
      chk(data_oe === 1'b0, "R2 ce high", {7'b0, data_oe}, 8'h00);
      oe_n = 1;

      // R3 / R8 / R10: program 5Ah at 1003h
      program_byte(16'h1003, 8'h5A);
      rd_exp(16'h1003, 8'h80, 8'hBF, "R8 program dq7 complement");
      repeat (P) @(negedge clk);
      model[idx(16'h1003)] &= 8'h5A;
      rd_exp(16'h1003, model[idx(16'h1003)], 8'hFF, "R10 program done");

      // R1 / R3: skewed fourth write, AND behaviour
      prefix();
      wr(16'h5555, 8'hA0);
      wr_skew(16'h1003, 16'h3001, 8'h00, 8'h0F);
      rd_raw(16'h1003, v1);
      chk(v1[7] === 1'b1, "R8 dq7 of 0Fh", v1 & 8'h80, 8'h80);
      repeat (P) @(negedge clk);
      model[idx(16'h1003)] &= 8'h0F;
      rd_exp(16'h1003, model[idx(16'h1003)], 8'hFF, "R3 and R1 captured byte");
      rd_exp(16'h3001, 8'hFF, 8'hFF, "R1 late address unused");

      // R6: broken sequences
      wr(16'h5555, 8'hAA);
      wr(16'h2AAA, 8'h56);
      wr(16'h5555, 8'hA0);
      wr(16'h1003, 8'h00);
      rd_exp(16'h1003, model[idx(16'h1003)], 8'hFF, "R6 broken unlock");
      erase_prefix();
      wr(16'h1000, 8'h10);
      rd_exp(16'h1003, model[idx(16'h1003)], 8'hFF, "R6 bad chip erase");

      // R7: commands during busy ignored
      program_byte(16'h2001, 8'h00);
      program_byte(16'h2002, 8'h11);
      repeat (P) @(negedge clk);
      model[idx(16'h2001)] = 8'h00;
      rd_exp(16'h2001, 8'h00, 8'hFF, "R7 first program applied");
      rd_exp(16'h2002, 8'hFF, 8'hFF, "R7 busy program ignored");

      // R4 / R8 / R9: sector erase of sector 2
      program_byte(16'h2003, 8'h33);
      repeat (P + 2) @(negedge clk);
      model[idx(16'h2003)] = 8'h33;
      erase_prefix();
      wr(16'h2000, 8'h30);
      rd_raw(16'h2001, v1);
      rd_raw(16'h2001, v2);
      rd_raw(16'h2001, v3);
      chk(v1[7] === 1'b0, "R8 erase dq7 low", v1, 8'h00);
      chk((v1 & 8'h3F) === 8'h00, "R8 low bits zero", v1 & 8'h3F, 8'h00);
      chk(v1[6] !== v2[6], "R9 toggle 1->2", v2, {v1[7], ~v1[6], v1[5:0]});
      chk(v2[6] !== v3[6], "R9 toggle 2->3", v3, {v2[7], ~v2[6], v2[5:0]});
      repeat (S) @(negedge clk);
      for (int i = 0; i < 4; i++) model[idx(16'h2000) + i] = 8'hFF;
      rd_raw(16'h2003, v1);
      rd_raw(16'h2003, v2);
      chk(v1 === 8'hFF && v2 === 8'hFF, "R9 R4 sector erased stable", v2, 8'hFF);
      rd_exp(16'h2001, 8'hFF, 8'hFF, "R4 sector byte");
      rd_exp(16'h1003, model[idx(16'h1003)], 8'hFF, "R4 other sector kept");

      // R5: chip erase
      program_byte(16'h7000, 8'h81);
      repeat (P + 2) @(negedge clk);
      model[idx(16'h7000)] = 8'h81;
      rd_exp(16'h7000, 8'h81, 8'hFF, "R3 sector7 program");
      erase_prefix();
      wr(16'h5555, 8'h10);
      rd_exp(16'h7000, 8'h00, 8'h80, "R8 chip erase dq7");
      repeat (C) @(negedge clk);
      for (int i = 0; i < 64; i++) model[i] = 8'hFF;
      rd_exp(16'h7000, 8'hFF, 8'hFF, "R5 chip erased 7000");
      rd_exp(16'h1003, 8'hFF, 8'hFF, "R5 chip erased 1003");

      repeat (4) @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule